// File: doc/BRIEF.md
# Depth-Chained FIFO with Token Ring Control

This block builds one deep first-in/first-out buffer out of several equal slices of storage. Every slice sees the same write data, write request and read request. No address is decoded to pick a slice. Instead, two tokens circulate around a ring of slices: a write token and a read token. The slice holding the write token stores the incoming word. The slice holding the read token supplies the outgoing word. When a slice uses its last location for a write, it signals its successor, and the write token moves on. Reads pass the read token in the same way. The last slice hands over to the first.

A start-slot input, sampled during reset, chooses the slice that holds both tokens when reset ends. Reset empties every slice and returns all pointers to location zero. The global full flag is taken from the slice that owns the write token. The global empty flag is taken from the slice that owns the read token. Moving from one slice to the next costs no cycle, so a stream of accesses runs at one word per clock across slice boundaries. The block reports which slice accepted each access and which slice owns each token.

Top module: `chain_fifo`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `empty` is 1, `full` is 0, `rd_valid` is 0, and both `wr_owner` and `rd_owner` are one-hot at bit `first_slot`. Reset discards all stored words.
- R2: Words are read out in the order they were written, including across slice boundaries. A read accepted at a clock edge sets `rd_valid` to 1 and presents the word on `rd_data` after that edge, for one cycle.
- R3: The write token moves from slice i to slice (i+1) mod N at the edge where slice i accepts a write into its last location (index DEPTH-1). At every other edge, `wr_owner` is unchanged.
- R4: The read token moves from slice i to slice (i+1) mod N at the edge where slice i accepts a read from its last location. At every other edge, `rd_owner` is unchanged.
- R5: `full` is 1 exactly when the write-owner slice holds DEPTH words, which happens after N*DEPTH net writes. A write request while `full` is 1 is not accepted, and stored words are unchanged.
- R6: `empty` is 1 exactly when the read-owner slice holds no words, and both tokens are then in the same slice. A read request while `empty` is 1 is not accepted, and `rd_valid` stays 0.
- R7: `slice_wr_en` is one-hot at the write-owner bit when a write is accepted in the current cycle, and zero otherwise. `slice_rd_en` does the same for reads.
- R8: A read and a write requested in the same cycle are both accepted when the buffer is neither empty nor full, and the occupancy is unchanged.
- R9: The start slice is chosen only by `first_slot`. Token passing wraps from slice N-1 to slice 0.
- R10: Consecutive write requests, one per cycle, are all accepted across slice boundaries. From empty, N*DEPTH back-to-back writes make `full` rise after the last one, with no stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| first_slot | input | $clog2(N) | Slice that owns both tokens after reset |
| wr_en | input | 1 | Write request, shared by all slices |
| wr_data | input | DATA_W | Write data, shared by all slices |
| rd_en | input | 1 | Read request, shared by all slices |
| rd_valid | output | 1 | rd_data holds a word read at the previous edge |
| rd_data | output | DATA_W | Read data |
| full | output | 1 | Write-owner slice is full |
| empty | output | 1 | Read-owner slice is empty |
| slice_wr_en | output | N | Per-slice accepted-write strobe |
| slice_rd_en | output | N | Per-slice accepted-read strobe |
| wr_owner | output | N | One-hot write token position |
| rd_owner | output | N | One-hot read token position |

## Verification
The assertions assume that `first_slot` is below N whenever `rst` is high. They also assume that requests are sampled only at the rising edge, so a request held while full or empty is simply refused and is never an error. The stimulus keeps `first_slot` in the range 0 to 3 for four slices, and changes `wr_en`, `rd_en` and `wr_data` only on the falling edge. It deliberately includes requests against a full or empty buffer, so that the refusal paths are exercised.

// File: rtl/chain_pkg.sv
package chain_pkg;
  // Ring predecessor of slice i among n slices.
  function automatic int prev_idx(input int i, input int n);
    return (i + n - 1) % n;
  endfunction
endpackage

// File: rtl/chain_slice.sv
module chain_slice #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 8,
  parameter int IDX    = 0,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  first_slot,
  input  logic              wr_ok,
  input  logic              rd_ok,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xi_w,
  input  logic              xi_r,
  output logic              xo_w,
  output logic              xo_r,
  output logic              wr_tok,
  output logic              rd_tok,
  output logic              wr_acc,
  output logic              rd_acc,
  output logic              is_full,
  output logic              is_empty,
  output logic [DATA_W-1:0] q
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  cnt;

  assign wr_acc   = wr_ok & wr_tok;
  assign rd_acc   = rd_ok & rd_tok;
  assign xo_w     = wr_acc & (wptr == LAST);
  assign xo_r     = rd_acc & (rptr == LAST);
  assign is_full  = (cnt == CNT_W'(DEPTH));
  assign is_empty = (cnt == '0);

  // Storage without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr] <= wr_data;
    if (rd_acc) q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      wr_tok <= (first_slot == SEL_W'(IDX));
      rd_tok <= (first_slot == SEL_W'(IDX));
    end else begin
      if (wr_acc) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_acc) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      cnt    <= cnt + CNT_W'(wr_acc) - CNT_W'(rd_acc);
      wr_tok <= xi_w | (wr_tok & ~xo_w);
      rd_tok <= xi_r | (rd_tok & ~xo_r);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_acc |-> (cnt != CNT_W'(DEPTH)));  // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    rd_acc |-> (cnt != '0));  // R6
endmodule

// File: rtl/chain_rdmux.sv
module chain_rdmux #(
  parameter int N      = 4,
  parameter int DATA_W = 9
) (
  input  logic [N-1:0]        sel,
  input  logic [N*DATA_W-1:0] din,
  output logic [DATA_W-1:0]   dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++)
      if (sel[i]) dout = dout | din[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/chain_fifo.sv
module chain_fifo #(
  parameter int N      = 4,
  parameter int DEPTH  = 8,
  parameter int DATA_W = 9,
  localparam int SEL_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  first_slot,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic [N-1:0]      slice_wr_en,
  output logic [N-1:0]      slice_rd_en,
  output logic [N-1:0]      wr_owner,
  output logic [N-1:0]      rd_owner
);
  logic [N-1:0]        xo_w, xo_r, xi_w, xi_r, s_full, s_empty;
  logic [N*DATA_W-1:0] q_flat;
  logic [N-1:0]        rd_src;
  logic                wr_ok, rd_ok;

  assign full  = |(wr_owner & s_full);
  assign empty = |(rd_owner & s_empty);
  assign wr_ok = wr_en & ~full;
  assign rd_ok = rd_en & ~empty;

  for (genvar g = 0; g < N; g++) begin : g_slice
    assign xi_w[g] = xo_w[chain_pkg::prev_idx(g, N)];
    assign xi_r[g] = xo_r[chain_pkg::prev_idx(g, N)];
    chain_slice #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX(g), .SEL_W(SEL_W)) slice_i (
      .clk(clk), .rst(rst), .first_slot(first_slot),
      .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_data(wr_data),
      .xi_w(xi_w[g]), .xi_r(xi_r[g]), .xo_w(xo_w[g]), .xo_r(xo_r[g]),
      .wr_tok(wr_owner[g]), .rd_tok(rd_owner[g]),
      .wr_acc(slice_wr_en[g]), .rd_acc(slice_rd_en[g]),
      .is_full(s_full[g]), .is_empty(s_empty[g]),
      .q(q_flat[g*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_src   <= '0;
    end else begin
      rd_valid <= |slice_rd_en;
      if (|slice_rd_en) rd_src <= slice_rd_en;
    end
  end

  chain_rdmux #(.N(N), .DATA_W(DATA_W)) rdmux_i (
    .sel(rd_src), .din(q_flat), .dout(rd_data)
  );

  AST_WR_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_owner) == 1);  // R3
  AST_RD_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(rd_owner) == 1);  // R4
  AST_WR_TOKEN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (|xo_w) |=> wr_owner == $past({wr_owner[N-2:0], wr_owner[N-1]}));  // R3
  AST_WR_TOKEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(|xo_w) |=> $stable(wr_owner));  // R3
  AST_RD_TOKEN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (|xo_r) |=> rd_owner == $past({rd_owner[N-2:0], rd_owner[N-1]}));  // R4
  AST_RD_TOKEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(|xo_r) |=> $stable(rd_owner));  // R4
  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slice_wr_en) && $onehot0(slice_rd_en));  // R7
  AST_EMPTY_SAME_SLICE: assert property (@(posedge clk) disable iff (rst)
    empty |-> (wr_owner == rd_owner));  // R6
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    full |-> (slice_wr_en == '0));  // R5
endmodule

// File: tb/chain_fifo_tb.sv
module chain_fifo_tb_top;
  localparam int N = 4;
  localparam int D = 8;
  localparam int W = 9;
  localparam int TOT = N * D;

  typedef struct packed {
    logic wr;
    logic rd;
    int   n;
    int   occ;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1, 1'b0, 10, 10},  // fill across first boundary (R2, R3)
    '{1'b0, 1'b1,  3,  7},
    '{1'b1, 1'b1, 12,  7},  // simultaneous (R8)
    '{1'b0, 1'b1,  7,  0},  // drain (R4)
    '{1'b1, 1'b0, 32, 32},  // back-to-back to full (R10, R5)
    '{1'b1, 1'b0,  3, 32},  // writes refused while full (R5)
    '{1'b0, 1'b1, 32,  0},
    '{1'b0, 1'b1,  2,  0},  // reads refused while empty (R6)
    '{1'b1, 1'b1,  5,  1}
  };

  logic clk = 0, rst = 1;
  logic [1:0] first_slot = '0;
  logic wr_en = 0, rd_en = 0;
  logic [W-1:0] wr_data = '0;
  logic rd_valid, full, empty;
  logic [W-1:0] rd_data;
  logic [N-1:0] slice_wr_en, slice_rd_en, wr_owner, rd_owner;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] mq [$];
  int wo, ro, wl, rl;
  logic [W-1:0] seq = 9'h0A5;

  always #10 clk = ~clk;

  chain_fifo #(.N(N), .DEPTH(D), .DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .first_slot(first_slot),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .full(full), .empty(empty),
    .slice_wr_en(slice_wr_en), .slice_rd_en(slice_rd_en),
    .wr_owner(wr_owner), .rd_owner(rd_owner)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input int f);
    @(negedge clk);
    rst = 1; first_slot = 2'(f); wr_en = 0; rd_en = 0;
    repeat (2) @(negedge clk);
    chk(empty == 1'b1, "R1", "empty in reset", int'(empty), 1);
    rst = 0;
    mq.delete(); wo = f; ro = f; wl = 0; rl = 0;
    #1;
    chk(empty == 1'b1 && full == 1'b0, "R1", "flags after reset",
        int'({full, empty}), 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
    chk(wr_owner == N'(1 << f), "R9", "wr_owner after reset", int'(wr_owner), 1 << f);
    chk(rd_owner == N'(1 << f), "R9", "rd_owner after reset", int'(rd_owner), 1 << f);
  endtask

  task automatic do_cycle(input bit wr, input bit rd);
    bit wa, ra;
    logic [W-1:0] exp_d;
    @(negedge clk);
    wr_en = wr; rd_en = rd; wr_data = seq;
    wa = wr && (mq.size() < TOT);
    ra = rd && (mq.size() > 0);
    #1;
    chk(slice_wr_en == (wa ? N'(1 << wo) : N'(0)), "R7", "slice_wr_en",
        int'(slice_wr_en), wa ? (1 << wo) : 0);
    chk(slice_rd_en == (ra ? N'(1 << ro) : N'(0)), "R7", "slice_rd_en",
        int'(slice_rd_en), ra ? (1 << ro) : 0);
    @(posedge clk);
    #1;
    exp_d = '0;
    if (ra) begin
      exp_d = mq.pop_front();
      rl++;
      if (rl == D) begin rl = 0; ro = (ro + 1) % N; end
    end
    if (wa) begin
      mq.push_back(seq);
      seq = seq + 9'h03B;
      wl++;
      if (wl == D) begin wl = 0; wo = (wo + 1) % N; end
    end
    chk(rd_valid == ra, ra ? "R2" : "R6", "rd_valid", int'(rd_valid), int'(ra));
    if (ra) chk(rd_data == exp_d, "R2", "rd_data order", int'(rd_data), int'(exp_d));
    chk(wr_owner == N'(1 << wo), "R3", "wr_owner", int'(wr_owner), 1 << wo);
    chk(rd_owner == N'(1 << ro), "R4", "rd_owner", int'(rd_owner), 1 << ro);
  endtask

  task automatic check_flags(input int occ);
    chk(full == (occ == TOT), "R5", "full", int'(full), int'(occ == TOT));
    chk(empty == (occ == 0), "R6", "empty", int'(empty), int'(occ == 0));
  endtask

  initial begin
    do_reset(0);
    foreach (VECS[k]) begin
      for (int c = 0; c < VECS[k].n; c++) do_cycle(VECS[k].wr, VECS[k].rd);
      check_flags(VECS[k].occ);
    end
    do_cycle(0, 0);

    // R1/R9: reset with data present, start from slice 2.
    do_reset(2);
    do_cycle(0, 1);  // refused read (R6)
    for (int c = 0; c < 9; c++) do_cycle(1, 0);  // token to slice 3 (R3)
    chk(wr_owner == 4'b1000, "R3", "token after 9 writes", int'(wr_owner), 8);
    for (int c = 0; c < 15; c++) do_cycle(1, 0);  // wrap 3 -> 0 -> 1 (R9)
    chk(wr_owner == 4'b0010, "R9", "token wrapped", int'(wr_owner), 2);
    check_flags(24);
    for (int c = 0; c < 24; c++) do_cycle(0, 1);
    chk(rd_owner == 4'b0010, "R9", "read token wrapped", int'(rd_owner), 2);
    check_flags(0);
    do_cycle(0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule